// File: doc/BRIEF.md
# Page Write Buffer and Self-Timed Commit Controller

This block sits between a serial memory slave's bit-level engine and its storage array. Once the slave engine has seen a START, it tells the block about the address phase (a pulse carrying the 16-bit start address) and about each received data byte. The block holds those bytes in a one-row buffer, 64 bytes deep. A byte's slot in that buffer is set by the low address bits, and those bits wrap within the row. The block also decides, for every data byte, whether the slave should acknowledge it.

A write-control input guards the array. If write control is high at any moment between the START and the address pulse, that transaction is protected: its data bytes are refused and nothing is stored. The address bytes are still acknowledged, because that happens upstream.

The buffer is committed only when the STOP follows directly on an acknowledge slot. The commit is one self-timed cycle with a length counted in system clocks. During that cycle the block reports busy, ignores the bus, and drives one array write strobe for each loaded slot. When the cycle ends, the block's address pointer is moved to the byte after the last one written.

Top module: `page_commit_unit`

## Requirements
- R1: After reset, busy, memWe and ackValid are low and nextAddr is zero.
- R2: With write control low from START onward, each data byte accepted after the address pulse yields ackValid high with ackGive=1 in the following cycle. A byte pulse before the address pulse, or outside a transaction, yields no ackValid.
- R3: If wcLevel is high in any cycle from the START pulse through the address-pulse cycle, every data byte of that transaction gets ackGive=0, no write cycle starts, and the array is untouched. A high wcLevel seen only during the data bytes has no effect.
- R4: Data byte n (counting from 0) lands in slot (startAddr[5:0] + n) mod 64 of the row startAddr[ADDR_W-1:6]. The row bits never change. When more than 64 bytes are sent, the later byte for a slot replaces the earlier one.
- R5: During the write cycle, memWe pulses exactly once for each loaded slot and never for an unloaded one. The pulses come in increasing slot order, and memAddr is {row, slot}.
- R6: A write cycle starts only on a stopSeen pulse with stopAfterAck=1 in the data phase of an unprotected transaction that has at least one accepted byte. A stopSeen with stopAfterAck=0 discards the buffer and starts nothing.
- R7: A startSeen pulse arriving before the commit discards every buffered byte. The bytes of the new transaction are the only ones written.
- R8: busy goes high the cycle after the qualifying STOP and stays high for exactly max(WRITE_CYCLES, 64) cycles. While busy, the block ignores startSeen, addrLoad, byteValid and stopSeen and gives no ackValid.
- R9: The address pulse loads nextAddr with addrIn. When a write cycle completes, nextAddr becomes ({row, last written slot} + 1) mod 2^ADDR_W. This crosses into the next row (or wraps to zero) when the last slot is 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startSeen | input | 1 | One-cycle pulse: START or repeated START detected |
| stopSeen | input | 1 | One-cycle pulse: STOP detected |
| stopAfterAck | input | 1 | Qualifies stopSeen: STOP came right after an acknowledge slot |
| wcLevel | input | 1 | Write-control level, high protects the array |
| addrLoad | input | 1 | One-cycle pulse: both address bytes received |
| addrIn | input | ADDR_W | Start address, valid with addrLoad |
| byteValid | input | 1 | One-cycle pulse: a data byte received |
| byteData | input | 8 | Data byte, valid with byteValid |
| busy | output | 1 | Self-timed write cycle in progress |
| ackValid | output | 1 | An acknowledge decision is presented this cycle |
| ackGive | output | 1 | 1 = acknowledge the byte, 0 = NoAck |
| memWe | output | 1 | Array write strobe |
| memAddr | output | ADDR_W | Array write address |
| memData | output | 8 | Array write data |
| nextAddr | output | ADDR_W | Internal address pointer |

## Verification
The bench covers the whole grid of start offsets and burst lengths, including single-byte writes, a full row, and bursts longer than a row. A design that carried the increment into the row bits would scatter bytes into the next row and report a wrong nextAddr; a design that let the earlier byte win would leave stale data. Protection is tested with write control raised only at START, only on the address cycle, and only during data. A latch with the wrong window would either store protected data or refuse good data. The bench also sends an unqualified STOP, sends a repeated START mid-burst, disturbs the bus while busy, and finishes a write at the top of the address space. These cases expose a commit armed by any STOP, a buffer that survives a restart, a busy window that reacts to the bus, and a pointer that fails to wrap.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_DATA  = 2'd2,
    ST_WRITE = 2'd3
  } pwcState_e;

  // strobes from the controller into the page datapath
  typedef struct packed {
    logic clearBuf;
    logic loadAddr;
    logic storeByte;
    logic finish;
  } pwcStrobe_t;

endpackage

// File: rtl/pwc_datapath.sv
module pwc_datapath #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  pwc_pkg::pwcStrobe_t strobe,
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic [7:0]          byteData,
  input  logic [PAGE_W-1:0]   scanIdx,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [7:0]          memData,
  output logic                slotLoaded,
  output logic                anyLoaded,
  output logic [ADDR_W-1:0]   nextAddr
);

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int ROW_W      = ADDR_W - PAGE_W;

  logic [ROW_W-1:0]      rowBase;
  logic [PAGE_W-1:0]     wrPtr;
  logic [PAGE_W-1:0]     lastOff;
  logic [PAGE_BYTES-1:0] loadMask;
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [ADDR_W-1:0]     lastAddr;

  assign lastAddr = {rowBase, lastOff};

  // row, in-row pointer, pointer of the last stored byte, address counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowBase   <= '0;
      wrPtr     <= '0;
      lastOff   <= '0;
      anyLoaded <= 1'b0;
      nextAddr  <= '0;
    end else begin
      if (strobe.loadAddr) begin
        rowBase  <= addrIn[ADDR_W-1:PAGE_W];
        wrPtr    <= addrIn[PAGE_W-1:0];
        nextAddr <= addrIn;
      end
      if (strobe.storeByte) begin
        lastOff   <= wrPtr;
        wrPtr     <= wrPtr + 1'b1;   // only the in-row bits advance
        anyLoaded <= 1'b1;
      end
      if (strobe.finish) begin
        nextAddr <= lastAddr + 1'b1;
      end
      if (strobe.clearBuf || strobe.finish) begin
        anyLoaded <= 1'b0;
      end
    end
  end

  // one data register and one loaded flag per slot
  for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
    logic hit;
    assign hit = strobe.storeByte && (wrPtr == PAGE_W'(s));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        loadMask[s] <= 1'b0;
      end else if (strobe.clearBuf || strobe.finish) begin
        loadMask[s] <= 1'b0;
      end else if (hit) begin
        loadMask[s] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (hit) begin
        pageBuf[s] <= byteData;
      end
    end
  end

  assign memAddr    = {rowBase, scanIdx};
  assign memData    = pageBuf[scanIdx];
  assign slotLoaded = loadMask[scanIdx];

endmodule

// File: rtl/pwc_control.sv
module pwc_control #(
  parameter int PAGE_W       = 6,
  parameter int WRITE_CYCLES = 2000
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       startSeen,
  input  logic                       stopSeen,
  input  logic                       stopAfterAck,
  input  logic                       wcLevel,
  input  logic                       addrLoad,
  input  logic                       byteValid,
  input  logic                       anyLoaded,
  input  logic                       slotLoaded,
  output pwc_pkg::pwcStrobe_t        strobe,
  output logic [PAGE_W-1:0]          scanIdx,
  output logic                       busy,
  output logic                       memWe,
  output logic                       ackValid,
  output logic                       ackGive
);

  import pwc_pkg::*;

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int SPAN       = (WRITE_CYCLES > PAGE_BYTES) ? WRITE_CYCLES : PAGE_BYTES;
  localparam int TIMER_W    = $clog2(SPAN) + 1;
  localparam logic [TIMER_W-1:0] LAST_TICK = TIMER_W'(SPAN - 1);
  localparam logic [TIMER_W-1:0] SCAN_LIM  = TIMER_W'(PAGE_BYTES);

  pwcState_e          state, stateNext;
  logic               wcSeen, wcNext;
  logic [TIMER_W-1:0] timer;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    wcNext    = wcSeen;
    unique case (state)
      ST_IDLE: begin
        if (startSeen) begin
          stateNext       = ST_ADDR;
          strobe.clearBuf = 1'b1;
          wcNext          = wcLevel;
        end
      end
      ST_ADDR: begin
        wcNext = wcSeen | wcLevel;
        if (startSeen) begin
          strobe.clearBuf = 1'b1;
          wcNext          = wcLevel;
        end else if (stopSeen) begin
          stateNext       = ST_IDLE;
          strobe.clearBuf = 1'b1;
        end else if (addrLoad) begin
          stateNext       = ST_DATA;
          strobe.loadAddr = 1'b1;
        end
      end
      ST_DATA: begin
        if (startSeen) begin
          stateNext       = ST_ADDR;
          strobe.clearBuf = 1'b1;
          wcNext          = wcLevel;
        end else if (stopSeen) begin
          if (stopAfterAck && anyLoaded && !wcSeen) begin
            stateNext = ST_WRITE;
          end else begin
            stateNext       = ST_IDLE;
            strobe.clearBuf = 1'b1;
          end
        end else if (byteValid && !wcSeen) begin
          strobe.storeByte = 1'b1;
        end
      end
      ST_WRITE: begin
        if (timer == LAST_TICK) begin
          stateNext     = ST_IDLE;
          strobe.finish = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      wcSeen   <= 1'b0;
      timer    <= '0;
      ackValid <= 1'b0;
      ackGive  <= 1'b0;
    end else begin
      state    <= stateNext;
      wcSeen   <= wcNext;
      timer    <= (state == ST_WRITE && stateNext == ST_WRITE) ? timer + 1'b1 : '0;
      ackValid <= (state == ST_DATA) && byteValid && !startSeen && !stopSeen;
      ackGive  <= !wcSeen;
    end
  end

  assign busy    = (state == ST_WRITE);
  assign scanIdx = timer[PAGE_W-1:0];
  assign memWe   = busy && (timer < SCAN_LIM) && slotLoaded;

endmodule

// File: rtl/page_commit_unit.sv
module page_commit_unit #(
  parameter int ADDR_W       = 16,
  parameter int PAGE_W       = 6,
  parameter int WRITE_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startSeen,
  input  logic              stopSeen,
  input  logic              stopAfterAck,
  input  logic              wcLevel,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  output logic              busy,
  output logic              ackValid,
  output logic              ackGive,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic [ADDR_W-1:0] nextAddr
);

  pwc_pkg::pwcStrobe_t strobe;
  logic [PAGE_W-1:0]   scanIdx;
  logic                slotLoaded;
  logic                anyLoaded;

  pwc_control #(
    .PAGE_W      (PAGE_W),
    .WRITE_CYCLES(WRITE_CYCLES)
  ) i_control (
    .clk         (clk),
    .rstN        (rstN),
    .startSeen   (startSeen),
    .stopSeen    (stopSeen),
    .stopAfterAck(stopAfterAck),
    .wcLevel     (wcLevel),
    .addrLoad    (addrLoad),
    .byteValid   (byteValid),
    .anyLoaded   (anyLoaded),
    .slotLoaded  (slotLoaded),
    .strobe      (strobe),
    .scanIdx     (scanIdx),
    .busy        (busy),
    .memWe       (memWe),
    .ackValid    (ackValid),
    .ackGive     (ackGive)
  );

  pwc_datapath #(
    .ADDR_W(ADDR_W),
    .PAGE_W(PAGE_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .addrIn    (addrIn),
    .byteData  (byteData),
    .scanIdx   (scanIdx),
    .memAddr   (memAddr),
    .memData   (memData),
    .slotLoaded(slotLoaded),
    .anyLoaded (anyLoaded),
    .nextAddr  (nextAddr)
  );

endmodule

// File: rtl/page_commit_checker.sv
module page_commit_checker #(
  parameter int ADDR_W       = 16,
  parameter int PAGE_W       = 6,
  parameter int WRITE_CYCLES = 2000
) (
  input logic              clk,
  input logic              rstN,
  input logic              startSeen,
  input logic              stopSeen,
  input logic              stopAfterAck,
  input logic              byteValid,
  input logic              busy,
  input logic              ackValid,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [ADDR_W-1:0] nextAddr
);

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int SPAN       = (WRITE_CYCLES > PAGE_BYTES) ? WRITE_CYCLES : PAGE_BYTES;

  int busyRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= 0;
    else       busyRun <= busy ? busyRun + 1 : 0;
  end

  assert_ack_follows_byte_R2: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> $past(byteValid));

  assert_we_inside_cycle_R5: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

  assert_commit_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopSeen && stopAfterAck));

  assert_plain_stop_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stopSeen && !stopAfterAck && !busy) |=> !busy);

  assert_start_no_commit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (startSeen && !busy) |=> !busy);

  assert_silent_when_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) |-> !ackValid);

  assert_busy_span_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == SPAN));

  assert_row_fixed_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(memAddr[ADDR_W-1:PAGE_W]));

  assert_pointer_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(nextAddr));

endmodule

bind page_commit_unit page_commit_checker #(
  .ADDR_W      (ADDR_W),
  .PAGE_W      (PAGE_W),
  .WRITE_CYCLES(WRITE_CYCLES)
) i_checker (
  .clk         (clk),
  .rstN        (rstN),
  .startSeen   (startSeen),
  .stopSeen    (stopSeen),
  .stopAfterAck(stopAfterAck),
  .byteValid   (byteValid),
  .busy        (busy),
  .ackValid    (ackValid),
  .memWe       (memWe),
  .memAddr     (memAddr),
  .nextAddr    (nextAddr)
);

// File: tb/test_page_commit_unit.sv
module test_page_commit_unit;

  localparam int ADDR_W = 10;
  localparam int PAGE_W = 6;
  localparam int WCYC   = 80;
  localparam int PAGE   = 1 << PAGE_W;
  localparam int MEMSZ  = 1 << ADDR_W;
  localparam int SPAN   = (WCYC > PAGE) ? WCYC : PAGE;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startSeen = 1'b0, stopSeen = 1'b0, stopAfterAck = 1'b0;
  logic              wcLevel = 1'b0, addrLoad = 1'b0, byteValid = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [7:0]        byteData = '0;
  logic              busy, ackValid, ackGive, memWe;
  logic [ADDR_W-1:0] memAddr, nextAddr;
  logic [7:0]        memData;

  page_commit_unit #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WCYC)) i_page_commit_unit (
    .clk(clk), .rstN(rstN), .startSeen(startSeen), .stopSeen(stopSeen),
    .stopAfterAck(stopAfterAck), .wcLevel(wcLevel), .addrLoad(addrLoad),
    .addrIn(addrIn), .byteValid(byteValid), .byteData(byteData), .busy(busy),
    .ackValid(ackValid), .ackGive(ackGive), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .nextAddr(nextAddr));

  always #5 clk = ~clk;

  int testsRun = 0, testsFailed = 0, cycles = 0;
  logic [7:0] arr    [MEMSZ];
  logic [7:0] expArr [MEMSZ];
  int writeCount = 0;
  int prevWeAddr = -1;
  int orderBad = 0;

  // array model fed by the write strobes, sampled mid-cycle
  always @(negedge clk) begin
    if (memWe) begin
      arr[memAddr] <= memData;
      writeCount   <= writeCount + 1;
      if (int'(memAddr) <= prevWeAddr) orderBad <= orderBad + 1;
      prevWeAddr <= int'(memAddr);
    end
    if (!busy) prevWeAddr <= -1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      testsFailed = testsFailed + 1;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doStart(input logic wc);
    @(negedge clk); startSeen = 1'b1; wcLevel = wc;
    @(negedge clk); startSeen = 1'b0;
  endtask

  task automatic doAddr(input int a, input logic wc);
    addrIn = ADDR_W'(a); addrLoad = 1'b1; wcLevel = wc;
    @(negedge clk); addrLoad = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] d, input logic expAck, input string req);
    byteValid = 1'b1; byteData = d;
    @(negedge clk); byteValid = 1'b0;
    check(ackValid === 1'b1 && ackGive === expAck, req, "byte acknowledge",
          {ackValid, ackGive}, {1'b1, expAck});
  endtask

  task automatic doStop(input logic afterAck, input logic expBusy, input string req);
    stopSeen = 1'b1; stopAfterAck = afterAck;
    @(negedge clk); stopSeen = 1'b0; stopAfterAck = 1'b0;
    check(busy === expBusy, req, "busy after STOP", int'(busy), int'(expBusy));
  endtask

  // counts busy cycles (the current one included); optionally pokes the bus
  task automatic waitIdle(input bit disturb, output int n);
    n = 0;
    while (busy === 1'b1 && n < 10000) begin
      n++;
      if (disturb && n == 3) begin
        startSeen = 1'b1; addrLoad = 1'b1; byteValid = 1'b1; stopSeen = 1'b1;
      end
      @(negedge clk);
      if (disturb && n == 3) begin
        startSeen = 1'b0; addrLoad = 1'b0; byteValid = 1'b0; stopSeen = 1'b0;
        check(ackValid === 1'b0, "R8", "ack while busy", int'(ackValid), 0);
      end
    end
  endtask

  task automatic compareArray(input string req);
    int bad = 0;
    for (int i = 0; i < MEMSZ; i++) if (arr[i] !== expArr[i]) bad++;
    check(bad == 0, req, "mismatching array bytes", bad, 0);
  endtask

  // full page write with arithmetic expectation
  task automatic pageWrite(input int a, input int n, input int seed, input bit disturb);
    int w0, span, lastA, nSlots;
    w0 = writeCount;
    doStart(1'b0);
    doAddr(a, 1'b0);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      int slot;
      d = 8'((seed + i * 37) & 255);
      slot = (a & ~(PAGE - 1)) | ((a + i) & (PAGE - 1));
      expArr[slot] = d;
      lastA = slot;
      sendByte(d, 1'b1, "R2");
    end
    doStop(1'b1, 1'b1, "R6");
    waitIdle(disturb, span);
    check(span == SPAN, "R8", "busy length", span, SPAN);
    nSlots = (n > PAGE) ? PAGE : n;
    check(writeCount - w0 == nSlots, "R5", "write strobes", writeCount - w0, nSlots);
    check(nextAddr == ADDR_W'(lastA + 1), "R9", "pointer after cycle",
          int'(nextAddr), (lastA + 1) % MEMSZ);
    compareArray("R4");
  endtask

  initial begin
    int w0, span;
    for (int i = 0; i < MEMSZ; i++) begin arr[i] = 8'hFF; expArr[i] = 8'hFF; end
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && memWe === 1'b0 && ackValid === 1'b0 && nextAddr === '0,
          "R1", "reset outputs", {busy, memWe, ackValid}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // byte write
    pageWrite(10'h123, 1, 8'h5A, 1'b0);

    // sweep of offsets and lengths over every row
    for (int k = 0; k < 10; k++) begin
      for (int j = 0; j < 5; j++) begin
        int lens [5] = '{1, 3, 33, 64, 67};
        pageWrite(((k * 3 + j) % 16) * PAGE + k * 7, lens[j], k * 11 + j, 1'b0);
      end
    end

    // top of the address space: pointer wraps to zero
    pageWrite(MEMSZ - 1, 1, 8'h77, 1'b0);
    check(nextAddr == '0, "R9", "pointer wrap at top", int'(nextAddr), 0);

    // bus activity during the write cycle is ignored
    pageWrite(10'h040, 5, 8'h31, 1'b1);
    @(negedge clk);
    byteValid = 1'b1; @(negedge clk); byteValid = 1'b0;
    check(ackValid === 1'b0, "R2", "byte outside transaction", int'(ackValid), 0);

    // protection: high at START only
    w0 = writeCount;
    doStart(1'b1);
    doAddr(10'h080, 1'b0);
    sendByte(8'h01, 1'b0, "R3");
    sendByte(8'h02, 1'b0, "R3");
    doStop(1'b1, 1'b0, "R3");
    // protection: high only in the address cycle
    doStart(1'b0);
    doAddr(10'h090, 1'b1);
    wcLevel = 1'b0;
    sendByte(8'h03, 1'b0, "R3");
    doStop(1'b1, 1'b0, "R3");
    repeat (2) @(negedge clk);
    check(writeCount == w0, "R3", "writes under protection", writeCount - w0, 0);
    compareArray("R3");

    // protection raised only during data has no effect
    doStart(1'b0);
    doAddr(10'h0A5, 1'b0);
    wcLevel = 1'b1;
    expArr[10'h0A5] = 8'hC3;
    sendByte(8'hC3, 1'b1, "R3");
    wcLevel = 1'b0;
    doStop(1'b1, 1'b1, "R3");
    waitIdle(1'b0, span);
    compareArray("R3");

    // byte before the address pulse gets no decision
    doStart(1'b0);
    byteValid = 1'b1; @(negedge clk); byteValid = 1'b0;
    check(ackValid === 1'b0, "R2", "byte before address", int'(ackValid), 0);
    // STOP not after an acknowledge slot
    w0 = writeCount;
    doAddr(10'h100, 1'b0);
    sendByte(8'h44, 1'b1, "R2");
    doStop(1'b0, 1'b0, "R6");
    doStop(1'b1, 1'b0, "R6");
    repeat (2) @(negedge clk);
    check(writeCount == w0, "R6", "writes after plain STOP", writeCount - w0, 0);

    // restart discards the buffer
    doStart(1'b0);
    doAddr(10'h200, 1'b0);
    sendByte(8'h10, 1'b1, "R7");
    sendByte(8'h11, 1'b1, "R7");
    doStart(1'b0);
    doAddr(10'h210, 1'b0);
    doStop(1'b1, 1'b0, "R7");
    doStart(1'b0);
    doAddr(10'h300, 1'b0);
    sendByte(8'h20, 1'b1, "R7");
    sendByte(8'h21, 1'b1, "R7");
    doStart(1'b0);
    doAddr(10'h305, 1'b0);
    expArr[10'h305] = 8'h99;
    sendByte(8'h99, 1'b1, "R7");
    doStop(1'b1, 1'b1, "R7");
    waitIdle(1'b0, span);
    check(writeCount == w0 + 1, "R7", "writes after restart", writeCount - w0, 1);
    compareArray("R7");

    check(orderBad == 0, "R5", "out-of-order strobes", orderBad, 0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule